// File: doc/BRIEF.md
# N-Dimensional Affine Stream Address Generator

This block walks a nested loop nest of up to eight levels and produces one element address per handshake. A stream is described by a 48-bit base address, a count of active dimensions, an element width code, and, for each dimension, a starting index, an element count and a signed byte stride. Every emitted address is the base plus the sum, over the active dimensions, of the current index of that dimension times its stride. Dimension 0 is the innermost loop, and the whole index vector advances like a mixed-radix counter.

Each address is tagged with the dimensions it closes and whether it closes the whole stream. It also carries its lane position inside a vector register and a lane-valid mask. The number of lanes per vector follows from the element width. A vector ends early when the innermost dimension runs out, and the lanes that will not be filled are masked off. A loop body can therefore consume the stream without index arithmetic or bound tests.

The start offset term is built by a serial shift-and-add over the index bits during a fixed setup phase. All later addresses come from per-dimension partial sums updated by adding strides, so no multiplier appears anywhere.

Top module: `stream_addr_gen`

## Requirements
- R1: Each emitted address equals (base + Σ over active k of (offset_k + n_k) × stride_k) modulo 2^48, where n_k counts from 0 to size_k − 1 and stride_k is a signed 32-bit byte value.
- R2: Dimension 0 is innermost. After its last element its counter returns to 0 and the next outer active dimension advances by one, carrying outward like a mixed-radix counter. The stream holds exactly the product of the active sizes in elements.
- R3: The active dimension count is taken from cfg_ndim_i, with 0 treated as 1 and values above NDIM treated as NDIM. Offsets, sizes and strides of inactive dimensions have no effect on any output.
- R4: eod_o bit k is 1 exactly on the element where dimension k and every dimension inside it are at their last index. Bits of inactive dimensions are always 0.
- R5: eos_o is 1 only on the final element of the stream. addr_valid_o is low in the cycle after that element is accepted, and it stays high from the first element to the last.
- R6: The lanes per vector equal VEC_BYTES >> cfg_ew_i, with element width codes 0 byte, 1 half-word, 2 word, 3 double-word. lane_o counts 0,1,… within a vector. vec_end_o marks the last lane or the last element of a dimension-0 sweep, and lane_o restarts at 0 after it.
- R7: lane_mask_o bit i is 1 exactly for lanes i of the current vector that will receive an element. It is all ones over the lane count when the sweep fills the vector, and it has trailing zeros when dimension 0 ends inside the vector.
- R8: While addr_valid_o is high and addr_ready_i low, every output holds its value.
- R9: The first addr_valid_o rises exactly IW clock edges after the edge that samples start_i.
- R10: start_i is ignored while a stream is in setup or running. The running stream continues unchanged.
- R11: A start whose configuration has an active dimension of size 0 produces no element.
- R12: After reset addr_valid_o, eos_o and eod_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, latches the configuration when idle |
| cfg_base_i | input | AW | Base byte address |
| cfg_ndim_i | input | NW | Active dimension count |
| cfg_ew_i | input | 2 | Element width code |
| cfg_off_i | input | NDIM*IW | Starting index per dimension, dimension k at bits [k*IW +: IW] |
| cfg_size_i | input | NDIM*IW | Element count per dimension |
| cfg_stride_i | input | NDIM*SW | Signed byte stride per dimension |
| addr_valid_o | output | 1 | Address available |
| addr_ready_i | input | 1 | Consumer accepts the address |
| addr_o | output | AW | Element byte address |
| eod_o | output | NDIM | Dimensions completed by this element |
| eos_o | output | 1 | Final element of the stream |
| lane_o | output | LW | Lane index within the vector |
| lane_mask_o | output | VEC_BYTES | Lanes of this vector that will be filled |
| vec_end_o | output | 1 | Last element of this vector |

## Verification
The stimulus covers several stream shapes. A single short dimension with word elements isolates the partial last vector. Two dimensions with a negative outer stride and double-word elements test signed stride handling and a mask that resets on every row. Three dimensions with byte elements and a base near zero show the 48-bit wraparound and long carry chains. A full eight-dimension walk shows carries through every level and all eod_o bits rising together at the end. Further runs use dimension counts of 0 and above NDIM with junk in the inactive fields to show that those fields are ignored. A zero-size stream, a second start pulse mid-stream and irregular ready patterns cover rejection and stall holding.

// File: rtl/sag_pkg.sv
package sag_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_INIT = 2'd1,
    ST_RUN  = 2'd2
  } sag_state_e;

  typedef enum logic [1:0] {
    EW_BYTE  = 2'd0,
    EW_HALF  = 2'd1,
    EW_WORD  = 2'd2,
    EW_DWORD = 2'd3
  } sag_ew_e;
endpackage

// File: rtl/sag_offset_init.sv
// Serial shift-and-add of sum(offset_k * stride_k), MSB first, IW cycles.
module sag_offset_init #(
  parameter int NDIM = 8,
  parameter int IW   = 16,
  parameter int SW   = 32,
  parameter int AW   = 48
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [NDIM-1:0]            act_i,
  input  logic [NDIM-1:0][IW-1:0]    off_i,
  input  logic [NDIM-1:0][SW-1:0]    stride_i,
  output logic                       done_o,
  output logic [AW-1:0]              acc_o
);
  localparam int BW = (IW > 1) ? $clog2(IW) : 1;

  logic          busy_q;
  logic [BW-1:0] bidx_q;
  logic [AW-1:0] acc_q;
  logic [AW-1:0] term;

  always_comb begin
    term = '0;
    for (int k = 0; k < NDIM; k++) begin
      if (act_i[k] && off_i[k][bidx_q])
        term = term + {{(AW-SW){stride_i[k][SW-1]}}, stride_i[k]};
    end
  end

  assign done_o = busy_q && (bidx_q == '0);
  assign acc_o  = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      bidx_q <= '0;
      acc_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      bidx_q <= BW'(IW-1);
      acc_q  <= '0;
    end else if (busy_q) begin
      acc_q <= {acc_q[AW-2:0], 1'b0} + term;
      if (bidx_q == '0) busy_q <= 1'b0;
      else              bidx_q <= bidx_q - 1'b1;
    end
  end
endmodule

// File: rtl/sag_dim.sv
// One loop level: element counter and running index*stride partial sum.
module sag_dim #(
  parameter int IW = 16,
  parameter int SW = 32,
  parameter int AW = 48
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  input  logic          wrap_i,
  input  logic          run_i,
  input  logic [IW-1:0] size_i,
  input  logic [SW-1:0] stride_i,
  output logic [IW-1:0] rem_o,
  output logic [AW-1:0] part_o
);
  logic [IW-1:0] cnt_q;
  logic [AW-1:0] part_q;

  assign rem_o  = size_i - cnt_q;
  assign part_o = part_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      part_q <= '0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      part_q <= '0;
    end else if (adv_i) begin
      if (wrap_i) begin
        cnt_q  <= '0;
        part_q <= '0;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        part_q <= part_q + {{(AW-SW){stride_i[SW-1]}}, stride_i};
      end
    end
  end

  assert_cnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < size_i));
endmodule

// File: rtl/sag_lane.sv
// Lane position and fill mask within a vector of VEC_BYTES bytes.
module sag_lane #(
  parameter int VEC_BYTES = 16,
  parameter int IW        = 16,
  localparam int LW       = $clog2(VEC_BYTES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 step_i,
  input  logic                 valid_i,
  input  logic [1:0]           ew_i,
  input  logic                 last0_i,
  input  logic [IW-1:0]        rem0_i,
  output logic [LW-1:0]        lane_o,
  output logic [VEC_BYTES-1:0] mask_o,
  output logic                 vec_end_o
);
  localparam int CW = ((IW > LW) ? IW : LW) + 2;

  logic [LW-1:0]        lane_q;
  logic [CW-1:0]        lanes;
  logic [CW-1:0]        fill;
  logic [VEC_BYTES:0]   ones;

  assign lanes = CW'(VEC_BYTES) >> ew_i;
  assign fill  = CW'(lane_q) + CW'(rem0_i);

  always_comb begin
    if (fill >= lanes) ones = ((VEC_BYTES+1)'(1) << lanes) - 1'b1;
    else               ones = ((VEC_BYTES+1)'(1) << fill) - 1'b1;
  end

  assign mask_o    = ones[VEC_BYTES-1:0];
  assign lane_o    = lane_q;
  assign vec_end_o = (CW'(lane_q) == lanes - 1'b1) || last0_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lane_q <= '0;
    else if (clr_i)   lane_q <= '0;
    else if (step_i)  lane_q <= vec_end_o ? '0 : lane_q + 1'b1;
  end

  assert_lane_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (CW'(lane_q) < lanes));
  assert_mask_lane_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> mask_o[lane_q]);
endmodule

// File: rtl/stream_addr_gen.sv
module stream_addr_gen
  import sag_pkg::*;
#(
  parameter int NDIM      = 8,
  parameter int IW        = 16,
  parameter int SW        = 32,
  parameter int AW        = 48,
  parameter int VEC_BYTES = 16,
  localparam int NW       = $clog2(NDIM + 1),
  localparam int LW       = $clog2(VEC_BYTES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [AW-1:0]        cfg_base_i,
  input  logic [NW-1:0]        cfg_ndim_i,
  input  logic [1:0]           cfg_ew_i,
  input  logic [NDIM*IW-1:0]   cfg_off_i,
  input  logic [NDIM*IW-1:0]   cfg_size_i,
  input  logic [NDIM*SW-1:0]   cfg_stride_i,
  output logic                 addr_valid_o,
  input  logic                 addr_ready_i,
  output logic [AW-1:0]        addr_o,
  output logic [NDIM-1:0]      eod_o,
  output logic                 eos_o,
  output logic [LW-1:0]        lane_o,
  output logic [VEC_BYTES-1:0] lane_mask_o,
  output logic                 vec_end_o
);
  sag_state_e                state_q;
  logic [AW-1:0]             base_q;
  logic [NW-1:0]             ndim_q;
  logic [1:0]                ew_q;
  logic [NDIM-1:0][IW-1:0]   off_q;
  logic [NDIM-1:0][IW-1:0]   size_q;
  logic [NDIM-1:0][SW-1:0]   stride_q;
  logic [NDIM-1:0][IW-1:0]   size_in;

  logic [NDIM-1:0]           act_q;
  logic [NDIM-1:0]           act_in;
  logic [NDIM-1:0]           last;
  logic [NDIM:0]             carry;
  logic [NDIM-1:0][IW-1:0]   rem;
  logic [NDIM-1:0][AW-1:0]   part;
  logic [AW-1:0]             part_sum;
  logic [AW-1:0]             init_acc;
  logic                      init_done;
  logic                      empty_in;
  logic                      accept;
  logic                      hs;

  assign size_in = cfg_size_i;

  for (genvar g = 0; g < NDIM; g++) begin : g_act
    if (g == 0) begin : g_inner
      assign act_q[g]  = 1'b1;
      assign act_in[g] = 1'b1;
    end else begin : g_outer
      assign act_q[g]  = (NW'(g) < ndim_q);
      assign act_in[g] = (NW'(g) < cfg_ndim_i);
    end
  end

  always_comb begin
    empty_in = 1'b0;
    for (int k = 0; k < NDIM; k++)
      if (act_in[k] && size_in[k] == '0) empty_in = 1'b1;
  end

  assign accept       = start_i && (state_q == ST_IDLE) && !empty_in;
  assign addr_valid_o = (state_q == ST_RUN);
  assign hs           = addr_valid_o && addr_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      base_q   <= '0;
      ndim_q   <= '0;
      ew_q     <= '0;
      off_q    <= '0;
      size_q   <= '0;
      stride_q <= '0;
    end else begin
      if (accept) begin
        base_q   <= cfg_base_i;
        ndim_q   <= cfg_ndim_i;
        ew_q     <= cfg_ew_i;
        off_q    <= cfg_off_i;
        size_q   <= cfg_size_i;
        stride_q <= cfg_stride_i;
      end
      unique case (state_q)
        ST_IDLE: if (accept)        state_q <= ST_INIT;
        ST_INIT: if (init_done)     state_q <= ST_RUN;
        ST_RUN:  if (hs && eos_o)   state_q <= ST_IDLE;
        default:                    state_q <= ST_IDLE;
      endcase
    end
  end

  sag_offset_init #(.NDIM(NDIM), .IW(IW), .SW(SW), .AW(AW)) u_init (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept),
    .act_i    (act_q),
    .off_i    (off_q),
    .stride_i (stride_q),
    .done_o   (init_done),
    .acc_o    (init_acc)
  );

  assign carry[0] = 1'b1;
  for (genvar g = 0; g < NDIM; g++) begin : g_dim
    assign last[g]    = !act_q[g] || (rem[g] == IW'(1));
    assign carry[g+1] = carry[g] && last[g];
    assign eod_o[g]   = addr_valid_o && act_q[g] && carry[g+1];

    sag_dim #(.IW(IW), .SW(SW), .AW(AW)) u_dim (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (accept),
      .adv_i    (hs && carry[g] && act_q[g]),
      .wrap_i   (last[g]),
      .run_i    (addr_valid_o && act_q[g]),
      .size_i   (size_q[g]),
      .stride_i (stride_q[g]),
      .rem_o    (rem[g]),
      .part_o   (part[g])
    );
  end

  always_comb begin
    part_sum = '0;
    for (int k = 0; k < NDIM; k++) part_sum = part_sum + part[k];
  end

  assign addr_o = base_q + init_acc + part_sum;
  assign eos_o  = addr_valid_o && carry[NDIM];

  sag_lane #(.VEC_BYTES(VEC_BYTES), .IW(IW)) u_lane (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (accept),
    .step_i    (hs),
    .valid_i   (addr_valid_o),
    .ew_i      (ew_q),
    .last0_i   (last[0]),
    .rem0_i    (rem[0]),
    .lane_o    (lane_o),
    .mask_o    (lane_mask_o),
    .vec_end_o (vec_end_o)
  );

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_o && !addr_ready_i) |=> (addr_valid_o && $stable(addr_o) &&
      $stable(eod_o) && $stable(lane_mask_o) && $stable(lane_o)));
  assert_eos_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs && eos_o) |=> !addr_valid_o);
  assert_eos_eod_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eos_o |-> (eod_o == act_q));
  assert_valid_after_init_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(addr_valid_o) |-> $past(state_q == ST_INIT));
  assert_start_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && state_q != ST_IDLE) |=> $stable(base_q));
endmodule

// File: tb/stream_addr_gen_bench.sv
module stream_addr_gen_bench;
  localparam int CLK_P = 10;
  localparam int NDIM  = 8;
  localparam int IW    = 16;
  localparam int SW    = 32;
  localparam int AW    = 48;
  localparam int VB    = 16;
  localparam int NW    = $clog2(NDIM + 1);
  localparam int LW    = $clog2(VB);

  typedef struct packed {
    logic [47:0] base;
    int          nd;
    int          ew;
    logic [7:0]  rdy;
    int o0; int o1; int o2;
    int s0; int s1; int s2;
    int t0; int t1; int t2;
  } tv_t;

  localparam int NTV = 4;
  localparam tv_t TV [NTV] = '{
    '{48'h1000,          1, 2, 8'hFF,       0, 0, 0,  5, 1, 1,  4,    0,     0},
    '{48'h8000_0000,     2, 3, 8'b10110101, 1, 2, 0,  3, 2, 1,  8, -100,     0},
    '{48'h0,             3, 0, 8'b01101101, 0, 0, 1,  2, 3, 2,  1,   16, -4096},
    '{48'hFFFF_FFFF_FFF0, 0, 1, 8'hFF,      3, 5, 9, 10, 3, 0,  2,  100,    77}
  };

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 start = 1'b0;
  logic [AW-1:0]        cfg_base = '0;
  logic [NW-1:0]        cfg_ndim = '0;
  logic [1:0]           cfg_ew = '0;
  logic [NDIM*IW-1:0]   cfg_off = '0;
  logic [NDIM*IW-1:0]   cfg_size = '0;
  logic [NDIM*SW-1:0]   cfg_stride = '0;
  logic                 ready = 1'b0;
  logic                 valid;
  logic [AW-1:0]        addr;
  logic [NDIM-1:0]      eod;
  logic                 eos;
  logic [LW-1:0]        lane;
  logic [VB-1:0]        mask;
  logic                 vend;

  int n_cmp = 0;
  int n_bad = 0;

  logic [47:0] t_base;
  int t_nd, t_ew;
  logic [7:0] t_rdy;
  int t_off [NDIM];
  int t_size [NDIM];
  int t_stride [NDIM];

  always #(CLK_P/2) clk = ~clk;

  stream_addr_gen #(.NDIM(NDIM), .IW(IW), .SW(SW), .AW(AW), .VEC_BYTES(VB)) u_stream_addr_gen (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .start_i      (start),
    .cfg_base_i   (cfg_base),
    .cfg_ndim_i   (cfg_ndim),
    .cfg_ew_i     (cfg_ew),
    .cfg_off_i    (cfg_off),
    .cfg_size_i   (cfg_size),
    .cfg_stride_i (cfg_stride),
    .addr_valid_o (valid),
    .addr_ready_i (ready),
    .addr_o       (addr),
    .eod_o        (eod),
    .eos_o        (eos),
    .lane_o       (lane),
    .lane_mask_o  (mask),
    .vec_end_o    (vend)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit is_act(input int k);
    return (k == 0) || (k < t_nd);
  endfunction

  task automatic clear_cfg();
    t_base = '0; t_nd = 1; t_ew = 0; t_rdy = 8'hFF;
    for (int k = 0; k < NDIM; k++) begin
      t_off[k] = 0; t_size[k] = 1; t_stride[k] = 0;
    end
  endtask

  task automatic apply_cfg();
    cfg_base = t_base;
    cfg_ndim = NW'(t_nd);
    cfg_ew   = 2'(t_ew);
    for (int k = 0; k < NDIM; k++) begin
      cfg_off[k*IW +: IW]    = IW'(t_off[k]);
      cfg_size[k*IW +: IW]   = IW'(t_size[k]);
      cfg_stride[k*SW +: SW] = SW'(t_stride[k]);
    end
  endtask

  task automatic run_stream(input bit inject);
    int cnt [NDIM];
    int lat, got, total, cyc, lane_e, lanes, rem, fill;
    bit done, stalled, injected, carry, lastk, last0;
    logic [47:0] prev_addr;
    longint a;
    logic [63:0] m_e;
    logic [NDIM-1:0] eod_e;

    apply_cfg();
    total = 1;
    for (int k = 0; k < NDIM; k++) begin
      cnt[k] = 0;
      if (is_act(k)) total = total * t_size[k];
    end
    @(negedge clk); start = 1'b1; ready = 1'b0;
    @(negedge clk); start = 1'b0;
    lat = 0;
    while (!valid && lat < 100) begin
      @(posedge clk); #1; lat++;
    end
    check("R9 setup latency", 64'(lat), 64'(IW));

    lane_e = 0; got = 0; cyc = 0; done = 0; stalled = 0; injected = 0; prev_addr = '0;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      if (inject && injected && start) begin
        start = 1'b0; cfg_base = t_base;
      end
      ready = t_rdy[cyc % 8];
      cyc++;
      #1;
      if (stalled) check("R8 hold on stall", 64'(addr), 64'(prev_addr));
      stalled = 0;
      if (!valid) begin
        check("R5 valid kept until last element", 64'(valid), 64'd1);
        continue;
      end
      if (!ready) begin
        stalled = 1; prev_addr = addr;
        continue;
      end
      a = longint'(t_base);
      for (int k = 0; k < NDIM; k++)
        if (is_act(k)) a = a + longint'(t_off[k] + cnt[k]) * longint'(t_stride[k]);
      carry = 1; eod_e = '0;
      for (int k = 0; k < NDIM; k++) begin
        lastk = !is_act(k) || (cnt[k] == t_size[k] - 1);
        if (is_act(k) && carry && lastk) eod_e[k] = 1'b1;
        carry = carry && lastk;
      end
      last0 = (cnt[0] == t_size[0] - 1);
      lanes = VB >> t_ew;
      rem = t_size[0] - cnt[0];
      fill = lane_e + rem;
      m_e = (fill >= lanes) ? ((64'd1 << lanes) - 1) : ((64'd1 << fill) - 1);
      check("R1 address", 64'(addr), 64'(a[47:0]));
      check("R4 eod flags", 64'(eod), 64'(eod_e));
      check("R5 eos flag", 64'(eos), 64'(carry));
      check("R6 lane index", 64'(lane), 64'(lane_e));
      check("R6 vector end", 64'(vend), 64'((lane_e == lanes - 1) || last0));
      check("R7 lane mask", 64'(mask), m_e);
      got++;
      lane_e = ((lane_e == lanes - 1) || last0) ? 0 : lane_e + 1;
      // R2: mixed-radix advance, dimension 0 innermost
      carry = 1;
      for (int k = 0; k < NDIM; k++) begin
        if (carry && is_act(k)) begin
          if (cnt[k] == t_size[k] - 1) cnt[k] = 0;
          else begin cnt[k]++; carry = 0; end
        end
      end
      if (eos) done = 1;
      if (inject && got == 2 && !injected) begin
        injected = 1; start = 1'b1; cfg_base = ~t_base;
      end
    end
    start = 1'b0; cfg_base = t_base;
    check("R2 element count", 64'(got), 64'(total));
    @(negedge clk); #1;
    check("R5 valid low after last", 64'(valid), 64'd0);
    ready = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int w;
    clear_cfg();
    apply_cfg();
    #(CLK_P * 3);
    #1;
    check("R12 reset valid", 64'(valid), 64'd0);
    check("R12 reset eos", 64'(eos), 64'd0);
    check("R12 reset eod", 64'(eod), 64'd0);
    @(negedge clk); rst_n = 1'b1;

    // table-driven stream shapes
    for (int i = 0; i < NTV; i++) begin
      clear_cfg();
      t_base = TV[i].base; t_nd = TV[i].nd; t_ew = TV[i].ew; t_rdy = TV[i].rdy;
      t_off[0] = TV[i].o0; t_off[1] = TV[i].o1; t_off[2] = TV[i].o2;
      t_size[0] = TV[i].s0; t_size[1] = TV[i].s1; t_size[2] = TV[i].s2;
      t_stride[0] = TV[i].t0; t_stride[1] = TV[i].t1; t_stride[2] = TV[i].t2;
      run_stream(1'b0);
    end

    // R2 R4: all eight dimensions, carry through every level
    clear_cfg();
    t_base = 48'h0000_1234_0000; t_nd = 8; t_ew = 3; t_rdy = 8'b11011110;
    for (int k = 0; k < NDIM; k++) begin
      t_off[k] = k; t_size[k] = 2; t_stride[k] = (k % 2 == 0) ? (8 << k) : -(3 << k);
    end
    run_stream(1'b0);

    // R3: count above NDIM clamps; count 0 with junk in outer fields
    clear_cfg();
    t_nd = 9; t_ew = 2; t_size[0] = 3; t_stride[0] = 4; t_off[7] = 2; t_stride[7] = 1000;
    run_stream(1'b0);
    clear_cfg();
    t_nd = 0; t_base = 48'h40; t_size[0] = 6; t_stride[0] = 8; t_off[0] = 1;
    t_size[1] = 0; t_off[1] = 7; t_stride[1] = 999;
    run_stream(1'b0);

    // R10: start pulse mid-stream is ignored
    clear_cfg();
    t_base = 48'h5000; t_nd = 2; t_ew = 2; t_rdy = 8'b01110111;
    t_size[0] = 3; t_size[1] = 3; t_stride[0] = 4; t_stride[1] = 64;
    run_stream(1'b1);

    // R11: zero-size active dimension yields nothing
    clear_cfg();
    t_nd = 2; t_size[0] = 4; t_size[1] = 0; t_stride[0] = 4;
    apply_cfg();
    @(negedge clk); start = 1'b1; ready = 1'b1;
    @(negedge clk); start = 1'b0;
    w = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk); #1;
      if (valid) w++;
    end
    check("R11 empty stream emits nothing", 64'(w), 64'd0);
    ready = 1'b0;

    // R11 follow-up: a normal stream still works afterwards
    clear_cfg();
    t_size[0] = 2; t_stride[0] = -8; t_base = 48'h100;
    run_stream(1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule